// File: doc/BRIEF.md
# Eight-bit ALU with carry-select addition

This block is a purely combinational arithmetic logic unit for an 8-bit datapath. It takes two operands, a carry input and a 2-bit operation code. It returns an 8-bit result and a carry output. The sum and three bitwise logic functions are all formed at the same time from the operands. A final multiplexer, steered by the operation code, passes one of them to the result.

The adder is a carry-select design built from 4-bit ripple-carry slices. The low slice adds bits 3..0 with the external carry input. The high slice is built twice: one copy assumes an incoming carry of 0 and the other assumes 1. The real carry out of the low slice then picks one copy's sum and carry. This way the upper bits do not wait for the lower ripple chain before they start. The slice width and the datapath width are parameters. With the defaults, the unit has one low slice and one duplicated high slice.

Top module: `alu8_csel`

## Requirements
- R1: With operation code 2'b00 (add), the result equals the low 8 bits of a + b + cin.
- R2: With operation code 2'b00, the carry output equals bit 8 of the 9-bit sum a + b + cin.
- R3: With operation code 2'b01 (invert), the result is the bitwise complement of a.
- R4: With operation code 2'b10 (and), the result is the bitwise AND of a and b.
- R5: With operation code 2'b11 (or), the result is the bitwise OR of a and b.
- R6: For operation codes 2'b01, 2'b10 and 2'b11, the carry output is 0 whatever the operands and carry input.
- R7: With operation code 2'b01, neither b nor cin has any effect on the result.
- R8: A carry out of bit 3 reaches the upper nibble: 0x0F + 0x01 with cin=0 gives 0x10 with carry output 0, and 0x08 + 0x08 with cin=0 gives 0x10.
- R9: A carry that ripples through all eight bits sets the carry output: 0xFF + 0x00 with cin=1 gives 0x00 with carry output 1, and 0xFF + 0xFF with cin=1 gives 0xFF with carry output 1.
- R10: The outputs follow the inputs within the same cycle, with no storage and no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry input, used only by addition |
| op_i | input | 2 | Operation code: 00 add, 01 invert a, 10 and, 11 or |
| res_o | output | 8 | Selected result |
| cout_o | output | 1 | Carry output of addition, 0 otherwise |

## Verification
Every value of a is paired with sixteen values of b that have equal nibbles (0x00, 0x11 up to 0xFF). Each pair is run with both carry inputs under all four operation codes. These pairs drive every combination of low-slice carry with both high-slice candidates, so a wrong select polarity or a swapped candidate shows up as a wrong upper nibble. The inversion code runs against varying b and cin, which shows whether those inputs leak into the result. Directed vectors at the nibble boundary and at full-width carry propagation separate a broken selector from a broken ripple chain.

// File: rtl/alu8_csel_pkg.sv
package alu8_csel_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_INV = 2'b01,
    OP_AND = 2'b10,
    OP_IOR = 2'b11
  } alu_op_e;

  // single-bit full adder, sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // single-bit full adder, carry output (majority)
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // two-way pick used by the carry-select stages
  function automatic logic pick_bit(input logic sel, input logic when0, input logic when1);
    return sel ? when1 : when0;
  endfunction

endpackage

// File: rtl/alu8_rca_slice.sv
module alu8_rca_slice
  import alu8_csel_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);

  logic [W:0] chain;
  assign chain[0] = ci_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign s_o[k]      = fa_sum(x_i[k], y_i[k], chain[k]);
    assign chain[k+1]  = fa_carry(x_i[k], y_i[k], chain[k]);
  end

  assign co_o = chain[W];

  // R1: bitwise ripple chain agrees with whole-word arithmetic
  always_comb begin
    p_slice_sum_r1: assert ({co_o, s_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i}))
      else $error("slice sum mismatch");
  end

endmodule

// File: rtl/alu8_csel_adder.sv
module alu8_csel_adder
  import alu8_csel_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NBLK = WIDTH / SLICE;

  // carry entering each slice; blk_carry[NBLK] is the final carry
  logic [NBLK:0] blk_carry;
  assign blk_carry[0] = cin_i;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    if (g == 0) begin : g_low
      alu8_rca_slice #(.W(SLICE)) u_low (
        .x_i (a_i[SLICE-1:0]),
        .y_i (b_i[SLICE-1:0]),
        .ci_i(blk_carry[0]),
        .s_o (sum_o[SLICE-1:0]),
        .co_o(blk_carry[1])
      );
    end else begin : g_dup
      logic [SLICE-1:0] cand_s0, cand_s1;
      logic             cand_c0, cand_c1;

      alu8_rca_slice #(.W(SLICE)) u_c0 (
        .x_i (a_i[g*SLICE +: SLICE]),
        .y_i (b_i[g*SLICE +: SLICE]),
        .ci_i(1'b0),
        .s_o (cand_s0),
        .co_o(cand_c0)
      );

      alu8_rca_slice #(.W(SLICE)) u_c1 (
        .x_i (a_i[g*SLICE +: SLICE]),
        .y_i (b_i[g*SLICE +: SLICE]),
        .ci_i(1'b1),
        .s_o (cand_s1),
        .co_o(cand_c1)
      );

      for (genvar k = 0; k < SLICE; k++) begin : g_pick
        assign sum_o[g*SLICE+k] = pick_bit(blk_carry[g], cand_s0[k], cand_s1[k]);
      end
      assign blk_carry[g+1] = pick_bit(blk_carry[g], cand_c0, cand_c1);

      // R8: assuming carry 1 never yields a smaller 5-bit value than assuming 0
      always_comb begin
        p_cand_order_r8: assert ({cand_c1, cand_s1} == {cand_c0, cand_s0} + 1'b1)
          else $error("carry-select candidates disagree");
      end
    end
  end

  assign cout_o = blk_carry[NBLK];

  // R2: the selected word matches the full-width sum
  always_comb begin
    p_csel_word_r2: assert ({cout_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("carry-select sum mismatch");
  end

endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] inv_o,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] ior_o
);

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign inv_o[k] = ~a_i[k];
    assign and_o[k] = a_i[k] & b_i[k];
    assign ior_o[k] = a_i[k] | b_i[k];
  end

endmodule

// File: rtl/alu8_csel.sv
module alu8_csel
  import alu8_csel_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);

  // internal results brought out as named wires
  logic [WIDTH-1:0] add_sum;
  logic             add_carry;
  logic [WIDTH-1:0] inv_res, and_res, ior_res;
  alu_op_e          op_dec;

  assign op_dec = alu_op_e'(op_i);

  alu8_csel_adder #(.WIDTH(WIDTH), .SLICE(SLICE)) u_add (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .sum_o (add_sum),
    .cout_o(add_carry)
  );

  alu8_logic_unit #(.WIDTH(WIDTH)) u_log (
    .a_i  (a_i),
    .b_i  (b_i),
    .inv_o(inv_res),
    .and_o(and_res),
    .ior_o(ior_res)
  );

  always_comb begin
    unique case (op_dec)
      OP_ADD:  res_o = add_sum;
      OP_INV:  res_o = inv_res;
      OP_AND:  res_o = and_res;
      default: res_o = ior_res;
    endcase
  end

  assign cout_o = (op_dec == OP_ADD) ? add_carry : 1'b0;

  always_comb begin
    if (op_dec == OP_INV) begin
      p_inv_r3: assert ((res_o ^ a_i) == {WIDTH{1'b1}})
        else $error("inversion result wrong");
    end
    if (op_dec == OP_AND) begin
      p_and_r4: assert (((res_o & ~a_i) == '0) && ((res_o & ~b_i) == '0) &&
                        ((a_i & b_i & ~res_o) == '0))
        else $error("and result wrong");
    end
    if (op_dec == OP_IOR) begin
      p_ior_r5: assert (((a_i & ~res_o) == '0) && ((b_i & ~res_o) == '0) &&
                        ((res_o & ~a_i & ~b_i) == '0))
        else $error("or result wrong");
    end
    if (op_dec != OP_ADD) begin
      p_logic_nocarry_r6: assert (cout_o == 1'b0)
        else $error("carry set on logic op");
    end
  end

endmodule

// File: tb/tb_alu8_csel.sv
module tb_alu8_csel;

  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic       cin;
  logic [1:0] op;
  logic [7:0] res;
  logic       cout;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  alu8_csel dut (
    .a_i   (a),
    .b_i   (b),
    .cin_i (cin),
    .op_i  (op),
    .res_o (res),
    .cout_o(cout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      misses = misses + 1;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // independent reference from the requirements
  function automatic logic [8:0] ref_out(input logic [7:0] x, input logic [7:0] y,
                                         input logic c, input logic [1:0] o);
    int s;
    case (o)
      2'b00: begin s = int'(x) + int'(y) + int'(c); return 9'(s); end  // R1 R2
      2'b01: return {1'b0, 8'(255 - int'(x))};                       // R3 R6
      2'b10: return {1'b0, x & y};                                   // R4 R6
      default: return {1'b0, x | y};                                 // R5 R6
    endcase
  endfunction

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic c,
                       input logic [1:0] o, input string tag);
    logic [8:0] e;
    @(posedge clk);
    a = x; b = y; cin = c; op = o;
    @(negedge clk);
    e = ref_out(x, y, c, o);
    vectors++;
    if (res !== e[7:0] || cout !== e[8]) begin
      misses++;
      $display("FAIL %s: a=%02h b=%02h cin=%0d op=%0d got res=%02h cout=%0d expected res=%02h cout=%0d",
               tag, x, y, c, o, res, cout, e[7:0], e[8]);
    end
  endtask

  task automatic expect_pair(input logic [7:0] er, input logic ec, input string tag);
    vectors++;
    if (res !== er || cout !== ec) begin
      misses++;
      $display("FAIL %s: got res=%02h cout=%0d expected res=%02h cout=%0d",
               tag, res, cout, er, ec);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; op = 2'b00;
    // R10: outputs present without any clock edge
    #1;
    expect_pair(8'h00, 1'b0, "R10 idle add of zeros");
    @(negedge clk);

    // sweep: every a, equal-nibble b, both carries, all ops (R1..R6)
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 16; ib++)
        for (int ic = 0; ic < 2; ic++)
          for (int io = 0; io < 4; io++)
            apply(8'(ia), 8'(ib * 17), 1'(ic), 2'(io),
                  io == 0 ? "R1/R2 add sweep" : (io == 1 ? "R3/R6 inv sweep" :
                  (io == 2 ? "R4/R6 and sweep" : "R5/R6 or sweep")));

    // R7: inversion ignores b and cin
    for (int ib = 0; ib < 256; ib += 7) begin
      apply(8'h5A, 8'(ib), 1'b1, 2'b01, "R7 inv ignores b,cin");
      expect_pair(8'hA5, 1'b0, "R7 inv fixed value");
    end

    // R8: nibble boundary carries
    apply(8'h0F, 8'h01, 1'b0, 2'b00, "R8 0F+01");
    expect_pair(8'h10, 1'b0, "R8 0F+01 literal");
    apply(8'h08, 8'h08, 1'b0, 2'b00, "R8 08+08");
    expect_pair(8'h10, 1'b0, "R8 08+08 literal");
    apply(8'h0F, 8'h00, 1'b1, 2'b00, "R8 0F+00+1");
    expect_pair(8'h10, 1'b0, "R8 0F+00+1 literal");

    // R9: full-width carry
    apply(8'hFF, 8'h00, 1'b1, 2'b00, "R9 FF+00+1");
    expect_pair(8'h00, 1'b1, "R9 FF+00+1 literal");
    apply(8'hFF, 8'hFF, 1'b1, 2'b00, "R9 FF+FF+1");
    expect_pair(8'hFF, 1'b1, "R9 FF+FF+1 literal");
    apply(8'hF0, 8'h10, 1'b0, 2'b00, "R9 F0+10");
    expect_pair(8'h00, 1'b1, "R9 F0+10 literal");

    // R6: logic ops with operands that would carry
    apply(8'hFF, 8'hFF, 1'b1, 2'b10, "R6 and no carry");
    apply(8'hFF, 8'hFF, 1'b1, 2'b11, "R6 or no carry");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule